// File: doc/BRIEF.md
# Drift-Corrected Real-Time Counter with Alarms and Timestamp

This block keeps wall-clock time from a slow tick strobe that nominally arrives 32768 times per second. The tick source may be a crystal or a cheap on-die RC oscillator. To cover the RC case, each tick adds a programmable step to a 32-bit fractional-second accumulator instead of a fixed count. The whole-second counter advances each time that accumulator wraps. Software measures the oscillator error elsewhere and writes a step slightly above or below nominal, and the counter then tracks true time.

Three alarm channels compare the running time against programmed values. When a counter update lands on an enabled channel's target, that channel raises a sticky flag. Flags can be routed to a wake output that keeps the rest of the system asleep until an alarm fires. One timestamp channel watches an asynchronous input and latches the current time on its rising edge. It reports a lost-edge condition when a second edge arrives before software has collected the first.

Software sees the block through a simple word-addressed register bus with a single-cycle write strobe and a combinational read. A read of one particular register has a side effect. Calendar conversion is left to software.

Top module: `rtc_comp_top`

## Requirements
- R1: After reset the seconds count, the visible fraction, the status word, `evt_o` and `wake_o` are all zero, and the step register (address 4) reads 0x0002_0000.
- R2: Each cycle with `tick_i` high adds the step register to a 32-bit accumulator that counts in units of 2^-32 s. A wrap of the accumulator adds one to the seconds count (address 2). The visible fraction (address 3, bits 15:0) is the accumulator's upper 16 bits. With the reset step, 32768 ticks make exactly one second. Without a tick or a load, both values hold.
- R3: A write to the step register (address 4) in the same cycle as a tick does not affect that tick, which still uses the old step. Every later tick uses the new value.
- R4: A write to address 2 loads the seconds count and zeroes the accumulator. A tick in the same cycle is discarded.
- R5: Channel k (k = 0..2) holds a target second at address 8+2k and an 8-bit target fraction at address 9+2k. Its flag (status bit k) sets two clock edges after a tick or load whose result has the target second and a visible-fraction upper byte equal to the target fraction. The channel must be enabled by control bit k (control is address 0). A disabled channel never sets its flag.
- R6: Alarm flags stay set until a write to status (address 1) with a 1 in the flag's bit position. If a set and a clear arrive together, the set wins. `evt_o` mirrors the three flags.
- R7: `wake_o` is high exactly when some flag k is set and its wake-enable, control bit 3+k, is set.
- R8: With control bit 6 set, a rising edge on `cap_in_i` passes through a two-stage synchronizer. The time is then latched on the third clock edge after the input changes: seconds at address 5 and the visible fraction at address 6. The same edge sets status bit 3 (holding).
- R9: An edge that arrives while holding is set leaves the stored time unchanged and sets status bit 4 (lost edge). A read of address 5 clears holding. Writing 1 to status bit 4 clears lost edge.
- R10: With control bit 6 clear, input edges change neither the stored time nor status bits 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe per raw slow-oscillator period |
| cap_in_i | input | 1 | Asynchronous timestamp trigger |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (used for the read side effect) |
| bus_addr_i | input | 4 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address |
| evt_o | output | 3 | Sticky alarm flags |
| wake_o | output | 1 | Wake request from enabled alarm flags |

## Verification
The hardest states to reach from the ports are the same-cycle collisions. A step write or a seconds load can land in the very cycle a tick is applied, and only the order of updates inside that cycle decides the result. The stimulus drives the bus strobe and the tick together at one falling edge, then reads the time back to show which value won. Long random runs with steps far from nominal force many accumulator wraps. A lost-edge condition is built by firing two timestamp edges at different times without reading in between.

// File: rtl/rtc_pkg.sv
// Package: register addresses and control-field positions shared by the
// real-time counter modules. Assumes at most four alarm channels so the
// alarm registers fit in the upper half of a 16-word map.
package rtc_pkg;
    localparam int unsigned ADDR_W   = 4;
    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_STAT  = 4'd1;
    localparam logic [ADDR_W-1:0] A_SEC   = 4'd2;
    localparam logic [ADDR_W-1:0] A_FRAC  = 4'd3;
    localparam logic [ADDR_W-1:0] A_STEP  = 4'd4;
    localparam logic [ADDR_W-1:0] A_CAPS  = 4'd5;
    localparam logic [ADDR_W-1:0] A_CAPF  = 4'd6;
    localparam int unsigned       ALM_BASE = 8;

    // Address of the target-second word of alarm channel k.
    function automatic logic [ADDR_W-1:0] alm_sec_addr(input int unsigned k);
        return ADDR_W'(ALM_BASE + 2 * k);
    endfunction

    // Address of the target-fraction word of alarm channel k.
    function automatic logic [ADDR_W-1:0] alm_frac_addr(input int unsigned k);
        return ADDR_W'(ALM_BASE + 2 * k + 1);
    endfunction
endpackage

// File: rtl/rtc_time_base.sv
// Time base: keeps the step register, the fractional accumulator and the
// whole-second count. Assumes tick_i is a single-cycle strobe already in
// the clk domain. A seconds load beats a tick in the same cycle, and a
// step write only affects ticks after the cycle it lands in.
module rtc_time_base #(
    parameter int unsigned SEC_W  = 32,
    parameter int unsigned ACC_W  = 32,
    parameter int unsigned FRAC_W = 16,
    parameter int unsigned TICK_LOG2 = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              step_wr_i,
    input  logic [ACC_W-1:0]  step_wdata_i,
    input  logic              sec_wr_i,
    input  logic [SEC_W-1:0]  sec_wdata_i,
    output logic [SEC_W-1:0]  sec_o,
    output logic [FRAC_W-1:0] frac_o,
    output logic [ACC_W-1:0]  step_o,
    output logic              upd_o
);
    localparam logic [ACC_W-1:0] STEP_NOM = ACC_W'(1) << (ACC_W - TICK_LOG2);

    logic [ACC_W-1:0] step_q;
    logic [ACC_W-1:0] acc_q;
    logic [SEC_W-1:0] sec_q;
    logic             upd_q;
    logic [ACC_W:0]   sum_w;

    // Accumulator plus step, with the wrap carry in the top bit.
    always_comb sum_w = {1'b0, acc_q} + {1'b0, step_q};

    // Step register: software-written, applied from the next tick on.
    always_ff @(posedge clk) begin
        if (!rst_n)         step_q <= STEP_NOM;
        else if (step_wr_i) step_q <= step_wdata_i;
    end

    // Time registers: load has priority over a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            sec_q <= '0;
        end else if (sec_wr_i) begin
            acc_q <= '0;
            sec_q <= sec_wdata_i;
        end else if (tick_i) begin
            acc_q <= sum_w[ACC_W-1:0];
            sec_q <= sec_q + SEC_W'(sum_w[ACC_W]);
        end
    end

    // Marks the cycle after the time value was written.
    always_ff @(posedge clk) begin
        if (!rst_n) upd_q <= 1'b0;
        else        upd_q <= sec_wr_i | tick_i;
    end

    assign sec_o  = sec_q;
    assign frac_o = acc_q[ACC_W-1 -: FRAC_W];
    assign step_o = step_q;
    assign upd_o  = upd_q;
endmodule

// File: rtl/rtc_alarm_bank.sv
// Alarm bank: NUM_CH channels, each with a target second and target
// fraction byte and a sticky flag. A flag sets only in the cycle after the
// time changed (upd_i) while the time matches, so rewriting a target equal
// to the present time does not fire. Set has priority over clear.
module rtc_alarm_bank #(
    parameter int unsigned NUM_CH = 3,
    parameter int unsigned SEC_W  = 32,
    parameter int unsigned FRAC_W = 16,
    parameter int unsigned TF_W   = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [SEC_W-1:0]              sec_i,
    input  logic [FRAC_W-1:0]             frac_i,
    input  logic                          upd_i,
    input  logic [NUM_CH-1:0]             en_i,
    input  logic [NUM_CH-1:0]             wr_sec_i,
    input  logic [NUM_CH-1:0]             wr_frac_i,
    input  logic [SEC_W-1:0]              wdata_i,
    input  logic [NUM_CH-1:0]             clr_i,
    output logic [NUM_CH-1:0]             flag_o,
    output logic [NUM_CH-1:0][SEC_W-1:0]  tgt_sec_o,
    output logic [NUM_CH-1:0][TF_W-1:0]   tgt_frac_o
);
    logic [TF_W-1:0] frac_top_w;

    // Only the upper fraction bits take part in a match.
    always_comb frac_top_w = frac_i[FRAC_W-1 -: TF_W];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [SEC_W-1:0] tsec_q;
        logic [TF_W-1:0]  tfrac_q;
        logic             flag_q;
        logic             hit_w;

        // Time equals this channel's target.
        always_comb hit_w = (sec_i == tsec_q) && (frac_top_w == tfrac_q);

        // Target registers, written from the bus.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tsec_q  <= '0;
                tfrac_q <= '0;
            end else begin
                if (wr_sec_i[g])  tsec_q  <= wdata_i;
                if (wr_frac_i[g]) tfrac_q <= wdata_i[TF_W-1:0];
            end
        end

        // Sticky flag: set on an enabled match after an update, else clear.
        always_ff @(posedge clk) begin
            if (!rst_n)                       flag_q <= 1'b0;
            else if (upd_i && hit_w && en_i[g]) flag_q <= 1'b1;
            else if (clr_i[g])                flag_q <= 1'b0;
        end

        assign flag_o[g]     = flag_q;
        assign tgt_sec_o[g]  = tsec_q;
        assign tgt_frac_o[g] = tfrac_q;
    end
endmodule

// File: rtl/rtc_stamp_unit.sv
// Timestamp unit: synchronizes an asynchronous input over two flops,
// detects its rising edge and latches the time. Assumes the input pulse is
// at least two clk periods wide in each level. While a stamp is held, a
// new edge keeps the old stamp and raises the lost-edge flag.
module rtc_stamp_unit #(
    parameter int unsigned SEC_W  = 32,
    parameter int unsigned FRAC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic              en_i,
    input  logic [SEC_W-1:0]  sec_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic              take_i,
    input  logic              lost_clr_i,
    output logic [SEC_W-1:0]  st_sec_o,
    output logic [FRAC_W-1:0] st_frac_o,
    output logic              held_o,
    output logic              lost_o
);
    logic [2:0]        sync_q;
    logic              rise_w;
    logic [SEC_W-1:0]  st_sec_q;
    logic [FRAC_W-1:0] st_frac_q;
    logic              held_q;
    logic              lost_q;

    // Two synchronizing stages and one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], trig_i};
    end

    // Enabled rising edge of the synchronized input.
    always_comb rise_w = en_i && sync_q[1] && !sync_q[2];

    // Stamp registers and holding flag; a read in the same cycle frees the slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_sec_q  <= '0;
            st_frac_q <= '0;
            held_q    <= 1'b0;
        end else if (rise_w && (!held_q || take_i)) begin
            st_sec_q  <= sec_i;
            st_frac_q <= frac_i;
            held_q    <= 1'b1;
        end else if (take_i) begin
            held_q    <= 1'b0;
        end
    end

    // Lost-edge flag: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                             lost_q <= 1'b0;
        else if (rise_w && held_q && !take_i)   lost_q <= 1'b1;
        else if (lost_clr_i)                    lost_q <= 1'b0;
    end

    assign st_sec_o  = st_sec_q;
    assign st_frac_o = st_frac_q;
    assign held_o    = held_q;
    assign lost_o    = lost_q;
endmodule

// File: rtl/rtc_comp_top.sv
// Top: drift-corrected real-time counter with alarm channels and one
// timestamp input. Decodes the register bus, holds the control word and
// assembles the status word. Assumes SEC_W and ACC_W equal DATA_W and
// NUM_CH is at most four.
module rtc_comp_top
    import rtc_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned SEC_W     = 32,
    parameter int unsigned ACC_W     = 32,
    parameter int unsigned FRAC_W    = 16,
    parameter int unsigned TF_W      = 8,
    parameter int unsigned NUM_CH    = 3,
    parameter int unsigned TICK_LOG2 = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 cap_in_i,
    input  logic                 bus_wr_i,
    input  logic                 bus_rd_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [DATA_W-1:0]    bus_wdata_i,
    output logic [DATA_W-1:0]    bus_rdata_o,
    output logic [NUM_CH-1:0]    evt_o,
    output logic                 wake_o
);
    localparam int unsigned CTRL_W   = 2 * NUM_CH + 1;
    localparam int unsigned CAPEN_B  = 2 * NUM_CH;
    localparam int unsigned HELD_B   = NUM_CH;
    localparam int unsigned LOST_B   = NUM_CH + 1;

    logic [CTRL_W-1:0]             ctrl_q;
    logic [SEC_W-1:0]              sec_w;
    logic [FRAC_W-1:0]             frac_w;
    logic [ACC_W-1:0]              step_w;
    logic                          upd_w;
    logic [NUM_CH-1:0]             flags_w;
    logic [NUM_CH-1:0][SEC_W-1:0]  tsec_w;
    logic [NUM_CH-1:0][TF_W-1:0]   tfrac_w;
    logic [NUM_CH-1:0]             wr_tsec_w;
    logic [NUM_CH-1:0]             wr_tfrac_w;
    logic [NUM_CH-1:0]             flag_clr_w;
    logic [SEC_W-1:0]              cap_sec_w;
    logic [FRAC_W-1:0]             cap_frac_w;
    logic                          cap_full_w;
    logic                          cap_ovf_w;
    logic                          wr_ctrl_w;
    logic                          wr_stat_w;
    logic                          wr_sec_w;
    logic                          wr_step_w;
    logic                          rd_caps_w;

    // Fixed-address write and read decodes.
    always_comb begin
        wr_ctrl_w = bus_wr_i && (bus_addr_i == A_CTRL);
        wr_stat_w = bus_wr_i && (bus_addr_i == A_STAT);
        wr_sec_w  = bus_wr_i && (bus_addr_i == A_SEC);
        wr_step_w = bus_wr_i && (bus_addr_i == A_STEP);
        rd_caps_w = bus_rd_i && (bus_addr_i == A_CAPS);
        flag_clr_w = wr_stat_w ? bus_wdata_i[NUM_CH-1:0] : '0;
    end

    // Per-channel alarm target write decodes.
    always_comb begin
        for (int k = 0; k < NUM_CH; k++) begin
            wr_tsec_w[k]  = bus_wr_i && (bus_addr_i == alm_sec_addr(k));
            wr_tfrac_w[k] = bus_wr_i && (bus_addr_i == alm_frac_addr(k));
        end
    end

    // Control word: alarm enables, wake enables, timestamp enable.
    always_ff @(posedge clk) begin
        if (!rst_n)         ctrl_q <= '0;
        else if (wr_ctrl_w) ctrl_q <= bus_wdata_i[CTRL_W-1:0];
    end

    rtc_time_base #(
        .SEC_W(SEC_W), .ACC_W(ACC_W), .FRAC_W(FRAC_W), .TICK_LOG2(TICK_LOG2)
    ) u_time (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .step_wr_i    (wr_step_w),
        .step_wdata_i (bus_wdata_i[ACC_W-1:0]),
        .sec_wr_i     (wr_sec_w),
        .sec_wdata_i  (bus_wdata_i[SEC_W-1:0]),
        .sec_o        (sec_w),
        .frac_o       (frac_w),
        .step_o       (step_w),
        .upd_o        (upd_w)
    );

    rtc_alarm_bank #(
        .NUM_CH(NUM_CH), .SEC_W(SEC_W), .FRAC_W(FRAC_W), .TF_W(TF_W)
    ) u_alarm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sec_i      (sec_w),
        .frac_i     (frac_w),
        .upd_i      (upd_w),
        .en_i       (ctrl_q[NUM_CH-1:0]),
        .wr_sec_i   (wr_tsec_w),
        .wr_frac_i  (wr_tfrac_w),
        .wdata_i    (bus_wdata_i[SEC_W-1:0]),
        .clr_i      (flag_clr_w),
        .flag_o     (flags_w),
        .tgt_sec_o  (tsec_w),
        .tgt_frac_o (tfrac_w)
    );

    rtc_stamp_unit #(
        .SEC_W(SEC_W), .FRAC_W(FRAC_W)
    ) u_stamp (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_i     (cap_in_i),
        .en_i       (ctrl_q[CAPEN_B]),
        .sec_i      (sec_w),
        .frac_i     (frac_w),
        .take_i     (rd_caps_w),
        .lost_clr_i (wr_stat_w && bus_wdata_i[LOST_B]),
        .st_sec_o   (cap_sec_w),
        .st_frac_o  (cap_frac_w),
        .held_o     (cap_full_w),
        .lost_o     (cap_ovf_w)
    );

    // Combinational read multiplexer.
    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            A_CTRL: bus_rdata_o = DATA_W'(ctrl_q);
            A_STAT: bus_rdata_o = DATA_W'({cap_ovf_w, cap_full_w, flags_w});
            A_SEC:  bus_rdata_o = DATA_W'(sec_w);
            A_FRAC: bus_rdata_o = DATA_W'(frac_w);
            A_STEP: bus_rdata_o = DATA_W'(step_w);
            A_CAPS: bus_rdata_o = DATA_W'(cap_sec_w);
            A_CAPF: bus_rdata_o = DATA_W'(cap_frac_w);
            default: begin
                for (int k = 0; k < NUM_CH; k++) begin
                    if (bus_addr_i == alm_sec_addr(k))  bus_rdata_o = DATA_W'(tsec_w[k]);
                    if (bus_addr_i == alm_frac_addr(k)) bus_rdata_o = DATA_W'(tfrac_w[k]);
                end
            end
        endcase
    end

    // Event and wake outputs from the sticky flags.
    always_comb begin
        evt_o  = flags_w;
        wake_o = |(flags_w & ctrl_q[2*NUM_CH-1:NUM_CH]);
    end
endmodule

// File: rtl/rtc_comp_checker.sv
// Checker: temporal properties of the real-time counter, bound into the
// top module. Observes ports and the internal time, flag and stamp state.
module rtc_comp_checker
    import rtc_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SEC_W  = 32,
    parameter int unsigned FRAC_W = 16,
    parameter int unsigned NUM_CH = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              bus_wr_i,
    input logic              bus_rd_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [DATA_W-1:0] bus_wdata_i,
    input logic [SEC_W-1:0]  sec,
    input logic [FRAC_W-1:0] frac,
    input logic [NUM_CH-1:0] flags,
    input logic [NUM_CH-1:0] alm_en,
    input logic              wake_o,
    input logic              cap_full,
    input logic              cap_ovf,
    input logic [SEC_W-1:0]  cap_sec
);
    logic              sec_load;
    logic [NUM_CH-1:0] keep;

    // Bus events the properties refer to.
    always_comb begin
        sec_load = bus_wr_i && (bus_addr_i == A_SEC);
        keep = flags & ~((bus_wr_i && bus_addr_i == A_STAT) ? bus_wdata_i[NUM_CH-1:0] : '0);
    end

    // R2: no tick and no load keeps the time
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !sec_load) |=> ($stable(frac) && $stable(sec)));

    // R2: a tick moves seconds by zero or one
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !sec_load) |=> ((sec == $past(sec)) || (sec == $past(sec) + 1'b1)));

    // R4: a load sets seconds and zeroes the fraction
    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sec_load |=> ((sec == $past(bus_wdata_i[SEC_W-1:0])) && (frac == '0)));

    // R5: a flag only rises on an enabled channel
    p_rise_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flags & ~$past(flags))) |-> ((flags & ~$past(flags) & ~$past(alm_en)) == '0));

    // R6: flags not being cleared stay set
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|keep) |=> ((flags & $past(keep)) == $past(keep)));

    // R7: wake needs a flag
    p_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (|flags));

    // R9: lost edge only arises while a stamp is held
    p_lost_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_ovf) |-> $past(cap_full));

    // R9: a held stamp is not overwritten until read
    p_keep_stamp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_full && !(bus_rd_i && bus_addr_i == A_CAPS)) |=> $stable(cap_sec));
endmodule

bind rtc_comp_top rtc_comp_checker #(
    .DATA_W(DATA_W), .SEC_W(SEC_W), .FRAC_W(FRAC_W), .NUM_CH(NUM_CH)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .bus_wr_i    (bus_wr_i),
    .bus_rd_i    (bus_rd_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .sec         (sec_w),
    .frac        (frac_w),
    .flags       (flags_w),
    .alm_en      (ctrl_q[NUM_CH-1:0]),
    .wake_o      (wake_o),
    .cap_full    (cap_full_w),
    .cap_ovf     (cap_ovf_w),
    .cap_sec     (cap_sec_w)
);

// File: tb/rtc_comp_tb_top.sv
// Bench: directed corners plus seeded random step values, checked
// against a reference time model kept in the bench.
module rtc_comp_tb_top;
    localparam logic [3:0] R_CTRL = 4'd0, R_STAT = 4'd1, R_SEC = 4'd2, R_FRAC = 4'd3;
    localparam logic [3:0] R_STEP = 4'd4, R_CAPS = 4'd5, R_CAPF = 4'd6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        cap_in = 1'b0;
    logic        bwr = 1'b0;
    logic        brd = 1'b0;
    logic [3:0]  baddr = '0;
    logic [31:0] bwdata = '0;
    logic [31:0] brdata;
    logic [2:0]  evt;
    logic        wake;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [31:0] m_sec = '0;
    logic [31:0] m_acc = '0;
    logic [31:0] m_step = 32'h0002_0000;

    always #2.5 clk = ~clk;

    rtc_comp_top dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .cap_in_i(cap_in),
        .bus_wr_i(bwr), .bus_rd_i(brd), .bus_addr_i(baddr),
        .bus_wdata_i(bwdata), .bus_rdata_o(brdata), .evt_o(evt), .wake_o(wake)
    );

    function automatic logic [31:0] m_frac();
        return {16'h0, m_acc[31:16]};
    endfunction

    task automatic m_tick();
        logic [32:0] s;
        s = {1'b0, m_acc} + {1'b0, m_step};
        m_acc = s[31:0];
        m_sec = m_sec + {31'h0, s[32]};
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_ticks(input int n);
        tick = 1'b1;
        for (int i = 0; i < n; i++) begin
            m_tick();
            @(negedge clk);
        end
        tick = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bwr = 1'b1; baddr = a; bwdata = d;
        @(negedge clk);
        bwr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        brd = 1'b1; baddr = a;
        #1 d = brdata;
        @(negedge clk);
        brd = 1'b0;
    endtask

    task automatic check_time(input string req);
        logic [31:0] v;
        rd(R_SEC, v);  check(req, v, m_sec);
        rd(R_FRAC, v); check(req, v, m_frac());
    endtask

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] st_sec;
        logic [31:0] st_frac;
        void'($urandom(32'd1234));
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        rd(R_SEC, v);  check("R1 sec", v, 0);
        rd(R_FRAC, v); check("R1 frac", v, 0);
        rd(R_STEP, v); check("R1 step", v, 32'h0002_0000);
        rd(R_STAT, v); check("R1 status", v, 0);
        check("R1 evt/wake", {28'h0, wake, evt}, 0);

        // R2: nominal step, one second per 32768 ticks
        do_ticks(32768);
        check_time("R2 one second");
        check("R2 exact second", m_sec, 1);
        do_ticks(3);
        check_time("R2 three ticks");

        // R2: seeded random step values, near nominal and arbitrary
        for (int it = 0; it < 14; it++) begin
            if (it % 3 == 2) m_step = $urandom;
            else             m_step = 32'h0002_0000 + ($urandom % 8192) - 32'd4096;
            wr(R_STEP, m_step);
            do_ticks(1 + int'($urandom % 300));
            check_time("R2 random step");
        end

        // R3: step write coinciding with a tick
        bwr = 1'b1; baddr = R_STEP; bwdata = 32'h4000_0001; tick = 1'b1;
        m_tick();
        @(negedge clk);
        bwr = 1'b0; tick = 1'b0;
        m_step = 32'h4000_0001;
        check_time("R3 old step on collision");
        do_ticks(1);
        check_time("R3 new step afterwards");

        // R4: seconds load beats a tick
        bwr = 1'b1; baddr = R_SEC; bwdata = 32'd1000; tick = 1'b1;
        @(negedge clk);
        bwr = 1'b0; tick = 1'b0;
        m_sec = 32'd1000; m_acc = '0;
        check_time("R4 load wins");

        // R5/R7: alarm 0 enabled with wake, alarm 1 same target but disabled
        m_step = 32'h0002_0000; wr(R_STEP, m_step);
        wr(4'd8, 5);  wr(4'd9, 2);
        wr(4'd10, 5); wr(4'd11, 2);
        wr(R_CTRL, 32'h09);
        wr(R_SEC, 5); m_sec = 5; m_acc = '0;
        do_ticks(255);
        idle(2);
        rd(R_STAT, v); check("R5 no flag before target", v, 0);
        check("R7 no wake before target", {31'h0, wake}, 0);
        do_ticks(1);
        idle(1);
        check("R5 alarm 0 only", {29'h0, evt}, 32'h1);
        check("R7 wake on enabled flag", {31'h0, wake}, 1);

        // R6: sticky, then cleared by writing 1
        idle(5);
        rd(R_STAT, v); check("R6 flag sticky", v, 32'h1);
        wr(R_STAT, 32'h1);
        rd(R_STAT, v); check("R6 flag cleared", v, 0);
        check("R7 wake drops", {31'h0, wake}, 0);

        // R7: alarm 2 fires without wake enable
        wr(4'd12, 5); wr(4'd13, 3);
        wr(R_CTRL, 32'h0D);
        do_ticks(128);
        idle(2);
        wr(R_STAT, 32'h1);
        check("R5 alarm 2 flag", {29'h0, evt}, 32'h4);
        check("R7 no wake without enable", {31'h0, wake}, 0);
        wr(R_STAT, 32'h1F);

        // R8: timestamp on a rising edge
        wr(R_CTRL, 32'h40);
        cap_in = 1'b1;
        idle(4);
        rd(R_STAT, v); check("R8 holding set", v, 32'h08);
        rd(R_CAPF, v); check("R8 stamp fraction", v, m_frac());
        rd(R_CAPS, v); check("R8 stamp seconds", v, m_sec);
        rd(R_STAT, v); check("R9 read clears holding", v, 0);

        // R9: second edge while held is lost
        cap_in = 1'b0; idle(3);
        do_ticks(10);
        cap_in = 1'b1; idle(4);
        st_sec = m_sec; st_frac = m_frac();
        do_ticks(10);
        cap_in = 1'b0; idle(3);
        cap_in = 1'b1; idle(4);
        rd(R_STAT, v); check("R9 lost edge", v, 32'h18);
        rd(R_CAPF, v); check("R9 first stamp kept", v, st_frac);
        wr(R_STAT, 32'h10);
        rd(R_STAT, v); check("R9 lost cleared", v, 32'h08);
        rd(R_CAPS, v); check("R9 first stamp seconds", v, st_sec);

        // R10: edges ignored while disabled
        wr(R_CTRL, 32'h0);
        cap_in = 1'b0; idle(3);
        do_ticks(7);
        cap_in = 1'b1; idle(4);
        rd(R_STAT, v); check("R10 no holding", v, 0);
        rd(R_CAPF, v); check("R10 stamp unchanged", v, st_frac);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule